// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This combinational block takes a 32-bit virtual address together with the current privilege mode, the access direction and the error-level status bit. It sorts the address into one of five fixed regions and decides whether the current mode may touch that region. Regions that bypass translation produce a physical address directly, with read and write both granted. Regions that need translation raise a lookup request toward an external translation buffer. The physical address, write permission and lookup status that come back from that buffer are then passed through.

Any failure becomes a single fault code plus a refill flag. The block also presents the values that the fault-address, context and entry-high registers should take when a fault is raised. The surrounding pipeline loads those registers whenever the fault output is high.

Top module: `addr_seg_decoder`

## Requirements
- R1: For an address with bit 31 clear while errLevel is 1, physAddr equals vaddr, permRead and permWrite are both 1, tlbReq is 0 and faultCode is 0, in every mode.
- R2: For an address with bit 31 clear while errLevel is 0, tlbReq is 1 in every mode, and the result follows the lookup status.
- R3: Addresses 0x80000000 to 0x9FFFFFFF in kernel mode (accMode 00) give physAddr = vaddr - 0x80000000 with read and write granted and no lookup.
- R4: Addresses 0xA0000000 to 0xBFFFFFFF in kernel mode give physAddr = vaddr - 0xA0000000 with read and write granted and no lookup.
- R5: Addresses 0xC0000000 to 0xDFFFFFFF request a lookup in supervisor (01) or kernel mode. In user mode they give an address error.
- R6: Addresses from 0xE0000000 upward request a lookup only in kernel mode. In any other mode they give an address error.
- R7: An access without enough privilege gives faultCode 1 on a read and 2 on a write (isWrite 1), with refill 0 and tlbReq 0.
- R8: tlbStatus encodes 0 hit, 1 no match, 2 invalid and 3 dirty. No match gives faultCode 3 on a read or 4 on a write, with refill 1. Invalid gives the same codes with refill 0. Dirty gives faultCode 5 with refill 0.
- R9: On a lookup hit, physAddr equals tlbPhys, permRead is 1, permWrite equals tlbWritable and faultCode is 0.
- R10: badAddrOut equals vaddr. ctxOut takes vaddr[31:13] in bits 22:4 and keeps every other bit of ctxIn.
- R11: entryHiOut takes vaddr[31:13] in bits 31:13, has bits 12:8 cleared, and keeps bits 7:0 of entryHiIn.
- R12: accMode 11 is treated exactly like user mode (10).
- R13: Whenever faultCode is nonzero, physAddr is 0 and both permission outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address being accessed |
| accMode | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 10/11 user |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| errLevel | input | 1 | Error-level status bit; when set, the low segment bypasses translation |
| tlbReq | output | 1 | Lookup request to the translation buffer |
| tlbStatus | input | 2 | Lookup result: 0 hit, 1 no match, 2 invalid, 3 dirty |
| tlbPhys | input | 32 | Physical address returned by the lookup |
| tlbWritable | input | 1 | Write permission returned by the lookup |
| physAddr | output | 32 | Resulting physical address, 0 on a fault |
| permRead | output | 1 | Read permission granted |
| permWrite | output | 1 | Write permission granted |
| faultCode | output | 3 | 0 none, 1 addr error load, 2 addr error store, 3 lookup load, 4 lookup store, 5 modify |
| refill | output | 1 | Set when the lookup fault came from a missing entry |
| ctxIn | input | 32 | Current context register value |
| entryHiIn | input | 32 | Current entry-high register value |
| badAddrOut | output | 32 | Value for the fault-address register |
| ctxOut | output | 32 | Value for the context register on a fault |
| entryHiOut | output | 32 | Value for the entry-high register on a fault |

## Verification
The hardest case to reach is the interaction between the lookup status and privilege. The lookup status must be ignored whenever the segment is direct or the privilege check fails. It must also be honoured for the low segment in every mode once errLevel is cleared. The stimulus therefore drives every lookup status and write permission against every region, mode, direction and errLevel value, with several address offsets inside each region, including both region edges. This shows that a stray status never leaks into a direct or forbidden access.

// File: rtl/addr_seg_pkg.sv
package addr_seg_pkg;

  typedef enum logic [2:0] {
    SEG_USER = 3'd0,
    SEG_KDIR = 3'd1,
    SEG_KRAW = 3'd2,
    SEG_SUPM = 3'd3,
    SEG_KMAP = 3'd4
  } segKind_t;

  typedef enum logic [1:0] {
    OFS_NONE = 2'd0,
    OFS_K8   = 2'd1,
    OFS_KA   = 2'd2
  } dirOfs_t;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ADEL = 3'd1,
    FLT_ADES = 3'd2,
    FLT_TLBL = 3'd3,
    FLT_TLBS = 3'd4,
    FLT_MOD  = 3'd5
  } fltCode_t;

  typedef struct packed {
    logic    useDirect;
    dirOfs_t dirOfs;
    logic    useTlb;
    logic    fault;
  } segStrobe_t;

endpackage

// File: rtl/addr_seg_ctrl.sv
module addr_seg_ctrl
  import addr_seg_pkg::*;
(
  input  logic [2:0]  vaTop,
  input  logic [1:0]  accMode,
  input  logic        isWrite,
  input  logic        errLevel,
  input  logic [1:0]  tlbStatus,
  output logic        tlbReq,
  output segStrobe_t  strobes,
  output fltCode_t    faultCode,
  output logic        refill
);

  segKind_t segKind;
  logic isKernel, isSuper, allowed, mapped, addrErr, tlbErr;

  always_comb begin
    isKernel = (accMode == 2'b00);
    isSuper  = (accMode == 2'b01);
    if (!vaTop[2])            segKind = SEG_USER;
    else if (vaTop == 3'b100) segKind = SEG_KDIR;
    else if (vaTop == 3'b101) segKind = SEG_KRAW;
    else if (vaTop == 3'b110) segKind = SEG_SUPM;
    else                      segKind = SEG_KMAP;
  end

  always_comb begin
    allowed = 1'b0;
    mapped  = 1'b0;
    strobes.dirOfs = OFS_NONE;
    unique case (segKind)
      SEG_USER: begin allowed = 1'b1; mapped = !errLevel; end
      SEG_KDIR: begin allowed = isKernel; strobes.dirOfs = OFS_K8; end
      SEG_KRAW: begin allowed = isKernel; strobes.dirOfs = OFS_KA; end
      SEG_SUPM: begin allowed = isKernel || isSuper; mapped = 1'b1; end
      default:  begin allowed = isKernel; mapped = 1'b1; end
    endcase
  end

  always_comb begin
    addrErr = !allowed;
    tlbReq  = allowed && mapped;
    tlbErr  = tlbReq && (tlbStatus != 2'd0);
    strobes.useTlb    = tlbReq;
    strobes.useDirect = allowed && !mapped;
    strobes.fault     = addrErr || tlbErr;
    refill    = 1'b0;
    faultCode = FLT_NONE;
    if (addrErr) begin
      faultCode = isWrite ? FLT_ADES : FLT_ADEL;
    end else if (tlbErr) begin
      unique case (tlbStatus)
        2'd1: begin faultCode = isWrite ? FLT_TLBS : FLT_TLBL; refill = 1'b1; end
        2'd2: faultCode = isWrite ? FLT_TLBS : FLT_TLBL;
        default: faultCode = FLT_MOD;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({vaTop, accMode, errLevel, tlbStatus})) begin
      // R7
      addr_err_no_lookup_chk: assert (!(tlbReq && faultCode inside {FLT_ADEL, FLT_ADES}));
      // R12
      user_kseg_chk: assert (!(accMode[1] && vaTop[2] && (faultCode != FLT_ADEL) && (faultCode != FLT_ADES)));
      // R8
      refill_code_chk: assert (!refill || (faultCode == FLT_TLBL) || (faultCode == FLT_TLBS));
    end
  end

endmodule

// File: rtl/addr_seg_datapath.sv
module addr_seg_datapath
  import addr_seg_pkg::*;
#(
  parameter int ASID_BITS = 8,
  parameter int PAIR_LSB  = 13,
  parameter int CTX_LSB   = 4
)(
  input  logic [31:0] vaddr,
  input  segStrobe_t  strobes,
  input  logic [31:0] tlbPhys,
  input  logic        tlbWritable,
  input  logic [31:0] ctxIn,
  input  logic [31:0] entryHiIn,
  output logic [31:0] physAddr,
  output logic        permRead,
  output logic        permWrite,
  output logic [31:0] badAddrOut,
  output logic [31:0] ctxOut,
  output logic [31:0] entryHiOut
);

  localparam int VPN_W  = 32 - PAIR_LSB;
  localparam int CTX_HI = CTX_LSB + VPN_W - 1;
  localparam int GAP_W  = PAIR_LSB - ASID_BITS;

  logic [31:0] dirBase;

  always_comb begin
    unique case (strobes.dirOfs)
      OFS_K8:  dirBase = 32'h8000_0000;
      OFS_KA:  dirBase = 32'hA000_0000;
      default: dirBase = 32'h0;
    endcase
  end

  always_comb begin
    physAddr  = 32'h0;
    permRead  = 1'b0;
    permWrite = 1'b0;
    if (!strobes.fault) begin
      if (strobes.useTlb) begin
        physAddr  = tlbPhys;
        permRead  = 1'b1;
        permWrite = tlbWritable;
      end else if (strobes.useDirect) begin
        physAddr  = vaddr - dirBase;
        permRead  = 1'b1;
        permWrite = 1'b1;
      end
    end
  end

  always_comb begin
    badAddrOut = vaddr;
    ctxOut = ctxIn;
    ctxOut[CTX_HI:CTX_LSB] = vaddr[31:PAIR_LSB];
    entryHiOut = {vaddr[31:PAIR_LSB], {GAP_W{1'b0}}, entryHiIn[ASID_BITS-1:0]};
  end

  always_comb begin
    if (!$isunknown({strobes, vaddr, entryHiIn})) begin
      // R13
      fault_no_perm_chk: assert (!strobes.fault || (physAddr == 32'h0 && !permRead && !permWrite));
      // R11
      entryhi_asid_chk: assert (entryHiOut[ASID_BITS-1:0] == entryHiIn[ASID_BITS-1:0]
                                && entryHiOut[PAIR_LSB-1:ASID_BITS] == '0);
    end
  end

endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
  import addr_seg_pkg::*;
#(
  parameter int ASID_BITS = 8,
  parameter int PAIR_LSB  = 13,
  parameter int CTX_LSB   = 4
)(
  input  logic [31:0] vaddr,
  input  logic [1:0]  accMode,
  input  logic        isWrite,
  input  logic        errLevel,
  output logic        tlbReq,
  input  logic [1:0]  tlbStatus,
  input  logic [31:0] tlbPhys,
  input  logic        tlbWritable,
  output logic [31:0] physAddr,
  output logic        permRead,
  output logic        permWrite,
  output logic [2:0]  faultCode,
  output logic        refill,
  input  logic [31:0] ctxIn,
  input  logic [31:0] entryHiIn,
  output logic [31:0] badAddrOut,
  output logic [31:0] ctxOut,
  output logic [31:0] entryHiOut
);

  segStrobe_t strobes;
  fltCode_t   fltCode;

  addr_seg_ctrl i_ctrl (
    .vaTop     (vaddr[31:29]),
    .accMode   (accMode),
    .isWrite   (isWrite),
    .errLevel  (errLevel),
    .tlbStatus (tlbStatus),
    .tlbReq    (tlbReq),
    .strobes   (strobes),
    .faultCode (fltCode),
    .refill    (refill)
  );

  addr_seg_datapath #(
    .ASID_BITS (ASID_BITS),
    .PAIR_LSB  (PAIR_LSB),
    .CTX_LSB   (CTX_LSB)
  ) i_dp (
    .vaddr       (vaddr),
    .strobes     (strobes),
    .tlbPhys     (tlbPhys),
    .tlbWritable (tlbWritable),
    .ctxIn       (ctxIn),
    .entryHiIn   (entryHiIn),
    .physAddr    (physAddr),
    .permRead    (permRead),
    .permWrite   (permWrite),
    .badAddrOut  (badAddrOut),
    .ctxOut      (ctxOut),
    .entryHiOut  (entryHiOut)
  );

  assign faultCode = fltCode;

  always_comb begin
    if (!$isunknown({vaddr, errLevel, accMode})) begin
      // R1
      direct_pass_chk: assert (!(errLevel && !vaddr[31]) || (physAddr == vaddr && faultCode == 3'd0 && !tlbReq));
    end
  end

endmodule

// File: tb/test_addr_seg_decoder.sv
module test_addr_seg_decoder;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] vaddr, tlbPhys, ctxIn, entryHiIn;
  logic [1:0]  accMode, tlbStatus;
  logic        isWrite, errLevel, tlbWritable;
  logic        tlbReq, permRead, permWrite, refill;
  logic [31:0] physAddr, badAddrOut, ctxOut, entryHiOut;
  logic [2:0]  faultCode;

  int errors = 0;
  int checks = 0;

  addr_seg_decoder i_addr_seg_decoder (
    .vaddr(vaddr), .accMode(accMode), .isWrite(isWrite), .errLevel(errLevel),
    .tlbReq(tlbReq), .tlbStatus(tlbStatus), .tlbPhys(tlbPhys), .tlbWritable(tlbWritable),
    .physAddr(physAddr), .permRead(permRead), .permWrite(permWrite),
    .faultCode(faultCode), .refill(refill), .ctxIn(ctxIn), .entryHiIn(entryHiIn),
    .badAddrOut(badAddrOut), .ctxOut(ctxOut), .entryHiOut(entryHiOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (va=%h mode=%0d wr=%0d erl=%0d st=%0d)",
               tag, act, exp, vaddr, accMode, isWrite, errLevel, tlbStatus);
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vaddr = 32'h0; accMode = 2'b00; isWrite = 1'b0; errLevel = 1'b1;
    tlbStatus = 2'd0; tlbPhys = 32'h0; tlbWritable = 1'b0;
    ctxIn = 32'h0; entryHiIn = 32'h0;
    @(negedge clk); #1;
    check("R1 idle phys", {32'h0, physAddr}, 64'h0);
    check("R1 idle fault", {61'h0, faultCode}, 64'h0);

    for (int rg = 0; rg < 8; rg++) begin
      for (int lo = 0; lo < 3; lo++) begin
        for (int md = 0; md < 4; md++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int el = 0; el < 2; el++) begin
              for (int st = 0; st < 4; st++) begin
                for (int tw = 0; tw < 2; tw++) begin
                  logic [31:0] va, xPhys;
                  logic xReq, xRd, xWr, xRef, kern, sup, ok, map;
                  logic [2:0] xCode;
                  logic [1:0] dirKind;
                  string tag;
                  case (lo)
                    0: va = {rg[2:0], 29'h0};
                    1: va = {rg[2:0], 29'h1FFF_FFFF};
                    default: va = {rg[2:0], 29'h0ABC_D123} ^ (rg * 32'h0101_2020);
                  endcase
                  va[31:29] = rg[2:0];
                  @(negedge clk);
                  vaddr = va; accMode = md[1:0]; isWrite = wr[0]; errLevel = el[0];
                  tlbStatus = st[1:0]; tlbWritable = tw[0];
                  tlbPhys = 32'h1234_5000 + rg * 32'h11 + lo;
                  ctxIn = 32'hDEAD_BEEF ^ va;
                  entryHiIn = 32'hCAFE_F0A5 + rg;
                  #1;
                  kern = (md == 0);
                  sup  = (md == 1);
                  dirKind = 2'd0;
                  if (rg < 4)       begin ok = 1'b1; map = (el == 0); tag = map ? "R2" : "R1"; end
                  else if (rg == 4) begin ok = kern; map = 1'b0; dirKind = 2'd1; tag = "R3"; end
                  else if (rg == 5) begin ok = kern; map = 1'b0; dirKind = 2'd2; tag = "R4"; end
                  else if (rg == 6) begin ok = kern || sup; map = 1'b1; tag = "R5"; end
                  else              begin ok = kern; map = 1'b1; tag = "R6"; end
                  if (md == 3 && !ok) tag = {tag, "/R12"};
                  xReq = ok && map;
                  xPhys = 32'h0; xRd = 1'b0; xWr = 1'b0; xRef = 1'b0; xCode = 3'd0;
                  if (!ok) begin
                    xCode = wr ? 3'd2 : 3'd1;
                  end else if (!map) begin
                    xPhys = va - ((dirKind == 1) ? 32'h8000_0000 : (dirKind == 2) ? 32'hA000_0000 : 32'h0);
                    xRd = 1'b1; xWr = 1'b1;
                  end else begin
                    case (st)
                      0: begin xPhys = tlbPhys; xRd = 1'b1; xWr = tw[0]; end
                      1: begin xCode = wr ? 3'd4 : 3'd3; xRef = 1'b1; end
                      2: xCode = wr ? 3'd4 : 3'd3;
                      default: xCode = 3'd5;
                    endcase
                  end
                  check({tag, " tlbReq"}, {63'h0, tlbReq}, {63'h0, xReq});
                  check({tag, (ok && map && st == 0) ? " R9 phys/perm" : " phys/perm"},
                        {30'h0, physAddr, permRead, permWrite}, {30'h0, xPhys, xRd, xWr});
                  check({tag, ok ? " R8 code" : " R7 code", (xCode != 0) ? " R13" : ""},
                        {60'h0, faultCode, refill}, {60'h0, xCode, xRef});
                  check("R10 badaddr/ctx", {badAddrOut, ctxOut},
                        {va, ctxIn[31:23], va[31:13], ctxIn[3:0]});
                  check("R11 entryhi", {32'h0, entryHiOut},
                        {32'h0, va[31:13], 5'b0, entryHiIn[7:0]});
                end
              end
            end
          end
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule